// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block decides which interrupt request an 8-bit processor core takes next. It serves up to nine request sources. Each source has a request flag, a per-source enable and a two-bit level built from a high bit and a low bit. A single global enable gates every source. When several sources are pending, the block takes the one with the highest level. Ties within a level go to the source that comes first in a fixed polling order.

On acceptance the block raises a one-cycle take strobe. With it come the 8-bit vector address, the index of the winning source, and a clear pulse for that source's flag when the flag is one that hardware must clear. A four-entry in-service mask tracks nesting, with one bit per level. A higher level can preempt the handler that is running. A return pulse retires the innermost handler, so the interrupted lower-level handler carries on.

Top module: `irq_lvl4_ctrl`

## Requirements
- R1: A source's level is `{lvl_hi[i], lvl_lo[i]}`: 2'b00 is level 0 (lowest), 2'b01 is level 1, 2'b10 is level 2 and 2'b11 is level 3 (highest). Among pending sources, one at the highest level is taken.
- R2: Among pending sources at the same level, the lowest index wins. Index 0 is polled first, then 1, 2 and so on up to 8.
- R3: On acceptance, `ack_src` carries the winning index and `ack_vec` carries 8'h03 + 8 × index: 03H, 0BH, 13H, 1BH, 23H, 2BH, 33H, 3BH and 43H for indices 0 to 8.
- R4: A source is pending only while `req_flag[i]`, `src_en[i]` and `glob_en` are all 1. With `glob_en` at 0, nothing is taken. A source whose enable is 0 is ignored, even when it has the highest level.
- R5: A pending request is taken only when no handler is in service, or when its level is strictly above the current level. The current level is the highest level in service. A request at an equal or lower level waits.
- R6: On acceptance, the bit of the accepted level is set in `in_svc`, and `cur_lvl` reports the highest set bit. A return pulse clears the highest set bit, so `cur_lvl` falls back to the level that was preempted.
- R7: No request is taken at a clock edge where `reti` is 1. A request held across that edge is taken at the next edge.
- R8: `flag_clr` pulses only the accepted source's bit, and only in the take cycle. Indices 1 and 3 (timer overflows) always get the pulse. Indices 0 and 2 (external inputs) get it only when `trig_edge` for that index is 1. Indices 4 to 8 never get it.
- R9: `ack`, `ack_vec`, `ack_src` and `flag_clr` are registered and are valid for one cycle. They appear in the cycle after the edge that samples the request. After reset, `ack` is 0, `in_svc` is 0 and `cur_lvl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_flag | input | 9 | Request flag of each source |
| src_en | input | 9 | Per-source enable |
| glob_en | input | 1 | Global enable for all sources |
| lvl_hi | input | 9 | High bit of each source's level |
| lvl_lo | input | 9 | Low bit of each source's level |
| trig_edge | input | 9 | 1 marks a transition-triggered input (used for indices 0 and 2) |
| reti | input | 1 | Return-from-interrupt pulse |
| ack | output | 1 | Take-interrupt strobe, one cycle |
| ack_vec | output | 8 | Vector address of the taken source |
| ack_src | output | 4 | Index of the taken source |
| flag_clr | output | 9 | Hardware-clear pulse for the taken source's flag |
| in_svc | output | 4 | In-service mask, one bit per level |
| cur_lvl | output | 2 | Highest level in service |

## Verification
The in-service mask is the state most likely to hide an error. A wrong bit set on acceptance, or the wrong bit cleared on return, shows up on `in_svc` and `cur_lvl` in the very next cycle. It also shows up later as a take or a refusal at the wrong moment. The bench therefore stacks levels 1, 2 and 3 and then unwinds them. While unwinding, it holds a same-level request pending and checks that the request is refused until its level drains. It then checks that the request is taken at the first edge where the mask empties. Priority and polling errors show as a wrong `ack_src` or `ack_vec` in the cycle right after the request is presented.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLVL = 4;
  typedef logic [1:0] lvl_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NSRC = 9,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] lvl_hi,
  input  logic [NSRC-1:0] lvl_lo,
  output logic            any,
  output logic [IW-1:0]   win_idx,
  output lvl_t            win_lvl
);
  // Walk from the last index down; ">=" lets a lower index take over an equal level
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && (!any || ({lvl_hi[i], lvl_lo[i]} >= win_lvl))) begin
        any     = 1'b1;
        win_idx = IW'(i);
        win_lvl = {lvl_hi[i], lvl_lo[i]};
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] in_svc,
  output lvl_t            cur_lvl,
  output logic            busy
);
  logic [NLVL-1:0] svc_q, svc_d;
  logic            svc_en;

  always_comb begin
    cur_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (svc_q[l]) cur_lvl = lvl_t'(l);
  end

  assign busy = |svc_q;

  always_comb begin
    svc_d  = svc_q;
    svc_en = 1'b0;
    if (pop && busy) begin
      svc_d[cur_lvl] = 1'b0;
      svc_en         = 1'b1;
    end else if (push) begin
      svc_d[push_lvl] = 1'b1;
      svc_en          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  assign in_svc = svc_q;

  AST_POP_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pop) && ($past(svc_q) != '0)) |-> ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R6
  AST_PUSH_ADDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(push) && !$past(pop)) |-> svc_q[$past(push_lvl)]); // R6
endmodule

// File: rtl/irq_lvl4_ctrl.sv
module irq_lvl4_ctrl
  import irq_pkg::*;
#(
  parameter int              NSRC     = 9,
  parameter int              VW       = 8,
  parameter logic [VW-1:0]   VEC_BASE = 8'h03,
  parameter int              VEC_STEP = 8,
  parameter logic [NSRC-1:0] FIX_CLR  = 9'b0_0000_1010,
  parameter logic [NSRC-1:0] TRIG_CLR = 9'b0_0000_0101,
  localparam int             IW       = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            glob_en,
  input  logic [NSRC-1:0] lvl_hi,
  input  logic [NSRC-1:0] lvl_lo,
  input  logic [NSRC-1:0] trig_edge,
  input  logic            reti,
  output logic            ack,
  output logic [VW-1:0]   ack_vec,
  output logic [IW-1:0]   ack_src,
  output logic [NSRC-1:0] flag_clr,
  output logic [NLVL-1:0] in_svc,
  output lvl_t            cur_lvl
);
  // Reset synchronizer: asserts at once, releases on the second clock edge
  logic [1:0] rst_sync;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  logic [NSRC-1:0] pend;
  logic            any;
  logic [IW-1:0]   win_idx;
  lvl_t            win_lvl;
  logic            busy;
  logic            accept;

  assign pend = req_flag & src_en & {NSRC{glob_en}};

  irq_pick #(.NSRC(NSRC)) u_pick (
    .pend    (pend),
    .lvl_hi  (lvl_hi),
    .lvl_lo  (lvl_lo),
    .any     (any),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign accept = any && !reti && (!busy || (win_lvl > cur_lvl));

  irq_nest u_nest (
    .clk      (clk),
    .rst_n    (rst_int),
    .push     (accept),
    .push_lvl (win_lvl),
    .pop      (reti),
    .in_svc   (in_svc),
    .cur_lvl  (cur_lvl),
    .busy     (busy)
  );

  logic            ack_q;
  logic [VW-1:0]   vec_q, vec_d;
  logic [IW-1:0]   src_q;
  logic [NSRC-1:0] clr_q, clr_d;

  always_comb begin
    vec_d = VEC_BASE + VW'(VEC_STEP * 32'(win_idx));
    for (int i = 0; i < NSRC; i++)
      clr_d[i] = accept && (win_idx == IW'(i)) && (FIX_CLR[i] || (TRIG_CLR[i] && trig_edge[i]));
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ack_q <= 1'b0;
      clr_q <= '0;
    end else begin
      ack_q <= accept;
      clr_q <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      vec_q <= '0;
      src_q <= '0;
    end else if (accept) begin
      vec_q <= vec_d;
      src_q <= win_idx;
    end
  end

  assign ack      = ack_q;
  assign ack_vec  = vec_q;
  assign ack_src  = src_q;
  assign flag_clr = clr_q;

  AST_NO_TAKE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_int)
    $past(reti) |-> !ack); // R7
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_int)
    !$past(glob_en) |-> !ack); // R4
  AST_TAKE_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_int)
    ack |-> (($past(in_svc) == '0) || (cur_lvl > $past(cur_lvl)))); // R5
  AST_CLR_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_int)
    (flag_clr != '0) |-> (ack && $onehot(flag_clr) && flag_clr[ack_src])); // R8
endmodule

// File: tb/sim_irq_lvl4_ctrl.sv
module sim_irq_lvl4_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] req_flag, src_en, lvl_hi, lvl_lo, trig_edge;
  logic       glob_en, reti;
  logic       ack;
  logic [7:0] ack_vec;
  logic [3:0] ack_src;
  logic [8:0] flag_clr;
  logic [3:0] in_svc;
  logic [1:0] cur_lvl;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_lvl4_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_flag(req_flag), .src_en(src_en),
    .glob_en(glob_en), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .trig_edge(trig_edge),
    .reti(reti), .ack(ack), .ack_vec(ack_vec), .ack_src(ack_src),
    .flag_clr(flag_clr), .in_svc(in_svc), .cur_lvl(cur_lvl)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic set_src(int s, int lvl);
    req_flag[s] = 1'b1;
    src_en[s]   = 1'b1;
    lvl_hi[s]   = lvl[1];
    lvl_lo[s]   = lvl[0];
  endtask

  task automatic expect_take(string req, int s);
    chk(req, "ack", int'(ack), 1);
    chk(req, "src", int'(ack_src), s);
    chk(req, "vec", int'(ack_vec), 8'h03 + 8 * s);
  endtask

  task automatic drain();
    req_flag = '0;
    reti     = 1'b1;
    repeat (4) tick();
    reti = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    chk("R9", "ack after reset", int'(ack), 0);
    chk("R9", "in_svc after reset", int'(in_svc), 0);
    chk("R9", "cur_lvl after reset", int'(cur_lvl), 0);
  endtask

  task automatic t_level();
    set_src(0, 0); set_src(3, 1); set_src(5, 3);
    tick();
    expect_take("R1", 5);
    chk("R1", "cur_lvl", int'(cur_lvl), 3);
    req_flag[5] = 1'b0;
    tick();
    chk("R9", "ack one cycle", int'(ack), 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R7", "no take on return edge", int'(ack), 0);
    tick();
    expect_take("R3", 3);
    drain();
  endtask

  task automatic t_poll();
    set_src(8, 2); set_src(7, 2); set_src(4, 2);
    tick();
    expect_take("R2", 4);
    drain();
    set_src(8, 0); set_src(6, 0);
    tick();
    expect_take("R2", 6);
    drain();
  endtask

  task automatic t_enable();
    glob_en = 1'b0;
    set_src(2, 3);
    tick();
    chk("R4", "global off", int'(ack), 0);
    tick();
    chk("R4", "global off held", int'(ack), 0);
    glob_en   = 1'b1;
    src_en[2] = 1'b0;
    set_src(7, 0);
    tick();
    expect_take("R4", 7);
    drain();
    src_en = '1;
  endtask

  task automatic t_nest();
    set_src(1, 1);
    tick();
    expect_take("R6", 1);
    chk("R6", "in_svc L1", int'(in_svc), 4'b0010);
    req_flag[1] = 1'b0;
    set_src(2, 1); set_src(0, 0);
    tick(); tick();
    chk("R5", "equal level waits", int'(ack), 0);
    set_src(6, 2);
    tick();
    expect_take("R5", 6);
    chk("R6", "in_svc L1+L2", int'(in_svc), 4'b0110);
    chk("R6", "cur_lvl 2", int'(cur_lvl), 2);
    req_flag[6] = 1'b0;
    set_src(8, 3);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    chk("R7", "take blocked by return", int'(ack), 0);
    chk("R6", "pop to L1", int'(in_svc), 4'b0010);
    tick();
    expect_take("R7", 8);
    chk("R6", "in_svc L1+L3", int'(in_svc), 4'b1010);
    req_flag[8] = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R6", "resume L1", int'(cur_lvl), 1);
    tick();
    chk("R5", "still waits at L1", int'(ack), 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R6", "mask empty", int'(in_svc), 0);
    tick();
    expect_take("R5", 2);
    drain();
  endtask

  task automatic t_clear();
    trig_edge = '0;
    set_src(1, 0); tick();
    chk("R8", "timer0 clear", int'(flag_clr), 9'b0_0000_0010);
    req_flag[1] = 1'b0; tick();
    chk("R9", "clear one cycle", int'(flag_clr), 0);
    drain();
    set_src(0, 0); tick();
    chk("R8", "level ext0 no clear", int'(flag_clr), 0);
    drain();
    trig_edge[0] = 1'b1;
    set_src(0, 0); tick();
    chk("R8", "edge ext0 clear", int'(flag_clr), 9'b0_0000_0001);
    drain();
    trig_edge = '1;
    set_src(4, 0); tick();
    chk("R8", "serial no clear", int'(flag_clr), 0);
    drain();
    set_src(3, 2); tick();
    chk("R8", "timer1 clear", int'(flag_clr), 9'b0_0000_1000);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; req_flag = '0; src_en = '1; glob_en = 1'b1;
    lvl_hi = '0; lvl_lo = '0; trig_edge = '0; reti = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_level();
    t_poll();
    t_enable();
    t_nest();
    t_clear();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule